// File: doc/BRIEF.md
# Approximate 8x8 Unsigned Tree Multiplier

This block multiplies two 8-bit unsigned operands and returns a 16-bit product in a single combinational path. Each bit pair of the operands is ANDed to form the 64-bit partial-product matrix. Row `i` holds `opnd_b` gated by `opnd_a[i]`, shifted left by `i`.

Two stages of 4-2 compression bring the eight rows down to two. The first stage compresses rows 0-3 and rows 4-7 separately. The second stage compresses the four resulting vectors: sum and shifted carry of the lower group, then sum and shifted carry of the upper group. A ripple-carry adder adds the last two rows.

Each compressor cell is chosen by its column, with column 0 as the LSB. In an approximate configuration, the cheapest approximate cell is used in the columns below `APPROX_COLS`. The column `COMP_COL` can receive a variant with a small error correction. All higher columns use exact cells that pass carries from column to column.

The `MODE` parameter selects one of three builds:
- plain approximation only;
- plain approximation with the corrected cell in `COMP_COL`;
- fully exact reduction.

The approximate builds are aimed at error-tolerant datapaths such as filters and inference, where low-order product bits may be wrong.

Top module: `approx_tree_mul`

## Requirements
- R1: With `MODE` set to the exact build, `product` equals `opnd_a * opnd_b` for every one of the 65,536 operand pairs. The partial-product bit at column `i+j` is `opnd_a[i] & opnd_b[j]`.
- R2: If either operand is zero, `product` is zero in every build.
- R3: If either operand is a power of two, `product` equals the exact product in every build.
- R4: In both approximate builds, with the defaults `APPROX_COLS`=7 and `COMP_COL`=6, the absolute difference between `product` and the exact product never exceeds 381. This is three approximate cells per column over columns 0-6. No carry leaves bit 15.
- R5: The plain approximate cell takes inputs x1..x4 and outputs carry = (x1|x2)&(x3|x4) and sum = x1|x2|x3|x4. Its value 2*carry+sum differs from the number of ones at the inputs by at most 1, and is exact when at most one input is set.
- R6: The corrected cell has the same carry as the plain cell. Its sum is inverted when exactly one of {x1,x2} and exactly one of {x3,x4} is set, so it never over-counts. Such a split two-one pattern gives value 2.
- R7: The exact 4-2 cell satisfies 2*(carry+cout)+sum = x1+x2+x3+x4+cin for all 32 input patterns. Its cout feeds the cin of the next column, and column 0 (or the first exact column in an approximate build) receives cin = 0.
- R8: Approximation is confined to columns 0-6 and correction to column 6. Bits 5:0 of `product` are therefore identical in the plain and corrected builds for every operand pair.
- R9: The final ripple-carry adder returns the exact 17-bit sum of its two 16-bit rows. Bit 0 is a half adder and the other bits are full adders.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 8 | Multiplicand, unsigned |
| opnd_b | input | 8 | Multiplier, unsigned |
| product | output | 16 | Product, exact or approximate depending on `MODE` |

## Verification
All operand pairs are swept through the exact, plain and corrected builds at the same time.

- **Exact build:** a cin chain broken at the approximate-to-exact boundary, or a lost top carry, shows up as a mismatch with `a*b`.
- **Approximate builds:** a build that placed approximate cells in a higher column breaks the 381 error bound or the shared low six bits. A cell that miscounts single ones fails the zero and power-of-two operands, where every cell sees at most one set input.
- **Cells on their own:** each cell is driven through all of its input patterns. An inverted or missing correction term, or a carry routed to the wrong pair, changes the split two-one patterns that separate the plain cell from the corrected one.

// File: rtl/atm_pkg.sv
// Package: shared constants and the build selector for the approximate tree multiplier.
// Assumes 8-bit unsigned operands; the two-group 4-2 tree is sized for eight rows.
package atm_pkg;
    localparam int OP_W   = 8;
    localparam int PROD_W = 2 * OP_W;
    localparam int GROUP  = 4;
    localparam int NGROUP = OP_W / GROUP;

    typedef enum logic [1:0] {
        MUL_PLAIN = 2'd0,
        MUL_COMP  = 2'd1,
        MUL_EXACT = 2'd2
    } mul_mode_e;
endpackage

// File: rtl/approx42_cell.sv
// Approximate 4-2 cell: no carry in or out; carry = (x1|x2)&(x3|x4), sum = OR of all.
// With COMPENSATE set, the sum is inverted when each pair holds exactly one 1,
// which removes the over-count on those patterns. Pairs are {x1,x2} and {x3,x4}.
module approx42_cell #(
    parameter bit COMPENSATE = 1'b0
) (
    input  logic x1,
    input  logic x2,
    input  logic x3,
    input  logic x4,
    output logic sum,
    output logic carry
);
    logic base_sum;
    logic [2:0] ones_w;
    logic [2:0] value_w;

    assign carry    = (x1 | x2) & (x3 | x4);
    assign base_sum = x1 | x2 | x3 | x4;

    if (COMPENSATE) begin : g_comp
        assign sum = base_sum ^ ((x1 ^ x2) & (x3 ^ x4));
    end else begin : g_plain
        assign sum = base_sum;
    end

    // Input population and output value, for the checks below.
    always_comb begin
        ones_w  = 3'(x1) + 3'(x2) + 3'(x3) + 3'(x4);
        value_w = {1'b0, carry, 1'b0} + 3'(sum);
    end

    // Checks the error window of the cell.
    always_comb begin
        // R5
        approx_err_chk: assert ((value_w <= ones_w + 3'd1) && (value_w + 3'd1 >= ones_w))
            else $error("approx cell error beyond one");
        // R5
        approx_low_chk: assert ((ones_w > 3'd1) || (value_w == ones_w))
            else $error("approx cell wrong on a single one");
    end

    if (COMPENSATE) begin : g_comp_chk
        // Checks the corrected cell never exceeds the true count.
        always_comb begin
            // R6
            comp_no_over_chk: assert (value_w <= ones_w)
                else $error("corrected cell over-counts");
        end
    end
endmodule

// File: rtl/exact42_cell.sv
// Exact 4-2 cell built from two full adders.
// The cout of the first adder goes to the next column; carry has weight 2.
module exact42_cell (
    input  logic x1,
    input  logic x2,
    input  logic x3,
    input  logic x4,
    input  logic cin,
    output logic sum,
    output logic carry,
    output logic cout
);
    logic mid;
    logic [2:0] lhs_w;
    logic [2:0] rhs_w;

    assign mid   = x1 ^ x2 ^ x3;
    assign cout  = (x1 & x2) | (x3 & (x1 ^ x2));
    assign sum   = mid ^ x4 ^ cin;
    assign carry = (mid & x4) | (cin & (mid ^ x4));

    // Weighs both sides of the cell for the identity check.
    always_comb begin
        lhs_w = {1'b0, carry, 1'b0} + {1'b0, cout, 1'b0} + 3'(sum);
        rhs_w = 3'(x1) + 3'(x2) + 3'(x3) + 3'(x4) + 3'(cin);
    end

    // Checks the exact cell preserves the weighted count.
    always_comb begin
        // R7
        exact42_sum_chk: assert (lhs_w == rhs_w)
            else $error("exact 4-2 cell count mismatch");
    end
endmodule

// File: rtl/compressor_row.sv
// One row of 4-2 cells across W columns, column 0 being the LSB.
// In approximate builds, columns below APPROX_COLS hold approximate cells, and
// COMP_COL holds the corrected cell in the MUL_COMP build. The exact cells above
// them chain cout to cin, starting from zero. carry_up is the carry vector
// already shifted to its column.
module compressor_row
    import atm_pkg::*;
#(
    parameter int        W           = 16,
    parameter mul_mode_e MODE        = MUL_COMP,
    parameter int        APPROX_COLS = 7,
    parameter int        COMP_COL    = 6
) (
    input  logic [W-1:0] x1,
    input  logic [W-1:0] x2,
    input  logic [W-1:0] x3,
    input  logic [W-1:0] x4,
    output logic [W-1:0] sum,
    output logic [W-1:0] carry_up
);
    localparam int LO = (MODE == MUL_EXACT) ? 0 : APPROX_COLS;

    logic [W-1:0] col_carry;
    logic [W:LO]  chain;

    assign chain[LO] = 1'b0;
    assign carry_up  = {col_carry[W-2:0], 1'b0};

    for (genvar j = 0; j < W; j++) begin : g_col
        if (j < LO) begin : g_apx
            approx42_cell #(
                .COMPENSATE((MODE == MUL_COMP) && (j == COMP_COL))
            ) u_cell (
                .x1(x1[j]), .x2(x2[j]), .x3(x3[j]), .x4(x4[j]),
                .sum(sum[j]), .carry(col_carry[j])
            );
        end else begin : g_ex
            exact42_cell u_cell (
                .x1(x1[j]), .x2(x2[j]), .x3(x3[j]), .x4(x4[j]),
                .cin(chain[j]), .sum(sum[j]), .carry(col_carry[j]),
                .cout(chain[j+1])
            );
        end
    end

    // Checks nothing of weight 2^W leaves the row.
    always_comb begin
        // R4
        row_top_chk: assert ((chain[W] == 1'b0) && (col_carry[W-1] == 1'b0))
            else $error("carry lost above the top column");
    end
endmodule

// File: rtl/ripple_adder.sv
// Ripple-carry adder for the last two rows: half adder at bit 0, full adders above.
module ripple_adder #(
    parameter int W = 16
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] s,
    output logic         co
);
    logic [W:1] cy;

    for (genvar k = 0; k < W; k++) begin : g_bit
        if (k == 0) begin : g_ha
            assign s[k]    = x[k] ^ y[k];
            assign cy[k+1] = x[k] & y[k];
        end else begin : g_fa
            assign s[k]    = x[k] ^ y[k] ^ cy[k];
            assign cy[k+1] = (x[k] & y[k]) | (cy[k] & (x[k] ^ y[k]));
        end
    end
    assign co = cy[W];

    // Checks the adder result against the arithmetic sum.
    always_comb begin
        // R9
        cpa_sum_chk: assert ({co, s} == ({1'b0, x} + {1'b0, y}))
            else $error("ripple adder sum mismatch");
    end
endmodule

// File: rtl/approx_tree_mul.sv
// Approximate 8x8 unsigned multiplier, fully combinational.
// Forms the AND partial-product rows, compresses rows 0-3 and 4-7 with 4-2 rows,
// compresses the four results with a second 4-2 row, then adds with a ripple adder.
// MODE selects the plain, corrected or exact build; the column limits apply
// only to the approximate builds.
module approx_tree_mul
    import atm_pkg::*;
#(
    parameter mul_mode_e MODE        = MUL_COMP,
    parameter int        APPROX_COLS = 7,
    parameter int        COMP_COL    = 6
) (
    input  logic [OP_W-1:0]   opnd_a,
    input  logic [OP_W-1:0]   opnd_b,
    output logic [PROD_W-1:0] product
);
    logic [PROD_W-1:0] pp_row [OP_W];
    logic [PROD_W-1:0] grp_sum [NGROUP];
    logic [PROD_W-1:0] grp_cy  [NGROUP];
    logic [PROD_W-1:0] fin_sum;
    logic [PROD_W-1:0] fin_cy;
    logic              cpa_co;

    // Partial-product rows: opnd_b gated by one bit of opnd_a, shifted to its weight.
    for (genvar i = 0; i < OP_W; i++) begin : g_pp
        assign pp_row[i] = {{OP_W{1'b0}}, opnd_b & {OP_W{opnd_a[i]}}} << i;
    end

    // First stage: one compressor row for each group of four partial-product rows.
    for (genvar g = 0; g < NGROUP; g++) begin : g_stage1
        compressor_row #(
            .W(PROD_W), .MODE(MODE), .APPROX_COLS(APPROX_COLS), .COMP_COL(COMP_COL)
        ) u_grp (
            .x1(pp_row[GROUP*g]),   .x2(pp_row[GROUP*g+1]),
            .x3(pp_row[GROUP*g+2]), .x4(pp_row[GROUP*g+3]),
            .sum(grp_sum[g]), .carry_up(grp_cy[g])
        );
    end

    // Second stage: the four vectors of stage one reduced to two.
    compressor_row #(
        .W(PROD_W), .MODE(MODE), .APPROX_COLS(APPROX_COLS), .COMP_COL(COMP_COL)
    ) u_final_row (
        .x1(grp_sum[0]), .x2(grp_cy[0]), .x3(grp_sum[1]), .x4(grp_cy[1]),
        .sum(fin_sum), .carry_up(fin_cy)
    );

    ripple_adder #(.W(PROD_W)) u_cpa (
        .x(fin_sum), .y(fin_cy), .s(product), .co(cpa_co)
    );

    // Checks the exact build and the top carry of the final adder.
    always_comb begin
        // R1
        exact_prod_chk: assert ((MODE != MUL_EXACT) ||
                                (product == PROD_W'(opnd_a) * PROD_W'(opnd_b)))
            else $error("exact build product mismatch");
        // R4
        cpa_top_chk: assert (cpa_co == 1'b0)
            else $error("final carry out of bit 15");
    end
endmodule

// File: tb/approx_tree_mul_test.sv
// Bench: sweeps all operand pairs through the three builds and checks each cell
// over all of its input patterns.
module approx_tree_mul_test;
    import atm_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;
    localparam int ERR_BOUND  = 381;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [7:0]  a_in = '0;
    logic [7:0]  b_in = '0;
    logic [15:0] p_comp, p_plain, p_exact;
    logic [4:0]  pat = '0;
    logic cp_s, cp_c, cc_s, cc_c, ce_s, ce_c, ce_co;

    int  checks = 0;
    int  errors = 0;
    int  cycles = 0;
    bit  finished = 1'b0;

    approx_tree_mul #(.MODE(MUL_COMP))  uut     (.opnd_a(a_in), .opnd_b(b_in), .product(p_comp));
    approx_tree_mul #(.MODE(MUL_PLAIN)) u_plain (.opnd_a(a_in), .opnd_b(b_in), .product(p_plain));
    approx_tree_mul #(.MODE(MUL_EXACT)) u_exact (.opnd_a(a_in), .opnd_b(b_in), .product(p_exact));

    approx42_cell #(.COMPENSATE(1'b0)) u_cell_plain (
        .x1(pat[0]), .x2(pat[1]), .x3(pat[2]), .x4(pat[3]), .sum(cp_s), .carry(cp_c));
    approx42_cell #(.COMPENSATE(1'b1)) u_cell_comp (
        .x1(pat[0]), .x2(pat[1]), .x3(pat[2]), .x4(pat[3]), .sum(cc_s), .carry(cc_c));
    exact42_cell u_cell_exact (
        .x1(pat[0]), .x2(pat[1]), .x3(pat[2]), .x4(pat[3]), .cin(pat[4]),
        .sum(ce_s), .carry(ce_c), .cout(ce_co));

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit is_pow2(input int v);
        return (v != 0) && ((v & (v - 1)) == 0);
    endfunction

    // Watchdog: a hung run counts as one failed check and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual %0d expected %0d", cycles, WATCHDOG);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Stimulus and checking.
    initial begin
        longint sum_abs_plain = 0;
        longint sum_abs_comp = 0;
        int     nerr_plain = 0;
        int     nerr_comp = 0;

        // Reset state: operands held at zero, so every build reads zero (R2).
        repeat (2) @(posedge clk);
        #1;
        check(p_comp == 16'd0,  "R2 reset comp",  p_comp, 0);
        check(p_plain == 16'd0, "R2 reset plain", p_plain, 0);
        check(p_exact == 16'd0, "R2 reset exact", p_exact, 0);
        rst_n = 1'b1;

        // Cell sweep: all patterns of each cell.
        for (int p = 0; p < 32; p++) begin
            int ones, vp, vc, exp_p, exp_c;
            bit split;
            @(negedge clk);
            pat = 5'(p);
            @(posedge clk);
            #1;
            ones  = int'(pat[0]) + int'(pat[1]) + int'(pat[2]) + int'(pat[3]);
            split = (pat[0] ^ pat[1]) & (pat[2] ^ pat[3]);
            if (ones == 4)                exp_c = 3;
            else if (ones == 2 && !split) exp_c = 1;
            else                          exp_c = ones;
            exp_p = (ones == 2 && split) ? 3 : exp_c;
            vp = 2 * int'(cp_c) + int'(cp_s);
            vc = 2 * int'(cc_c) + int'(cc_s);
            check(vp == exp_p, "R5 plain cell value", vp, exp_p);
            check(vc == exp_c, "R6 corrected cell value", vc, exp_c);
            check(2 * (int'(ce_c) + int'(ce_co)) + int'(ce_s) == ones + int'(pat[4]),
                  "R7 exact cell identity",
                  2 * (int'(ce_c) + int'(ce_co)) + int'(ce_s), ones + int'(pat[4]));
        end

        // Full operand sweep over the three builds.
        for (int ai = 0; ai < 256; ai++) begin
            for (int bi = 0; bi < 256; bi++) begin
                int ex, dp, dc;
                @(negedge clk);
                a_in = 8'(ai);
                b_in = 8'(bi);
                @(posedge clk);
                #1;
                ex = ai * bi;
                dp = int'(p_plain) - ex;
                dc = int'(p_comp) - ex;
                // R1 and R9: exact build equals the arithmetic product.
                check(int'(p_exact) == ex, "R1 R9 exact product", p_exact, ex);
                check(dp <= ERR_BOUND && dp >= -ERR_BOUND, "R4 plain error bound", p_plain, ex);
                check(dc <= ERR_BOUND && dc >= -ERR_BOUND, "R4 corrected error bound", p_comp, ex);
                check(p_plain[5:0] == p_comp[5:0], "R8 shared low bits",
                      p_comp[5:0], p_plain[5:0]);
                if (ai == 0 || bi == 0) begin
                    check(p_plain == 16'd0, "R2 zero operand plain", p_plain, 0);
                    check(p_comp == 16'd0,  "R2 zero operand corrected", p_comp, 0);
                end
                if (is_pow2(ai) || is_pow2(bi)) begin
                    check(int'(p_plain) == ex, "R3 power of two plain", p_plain, ex);
                    check(int'(p_comp) == ex,  "R3 power of two corrected", p_comp, ex);
                end
                if (dp != 0) nerr_plain++;
                if (dc != 0) nerr_comp++;
                sum_abs_plain += (dp < 0) ? -dp : dp;
                sum_abs_comp  += (dc < 0) ? -dc : dc;
            end
        end

        $display("plain build: error rate %0.2f%%, NMED %0.3e",
                 100.0 * real'(nerr_plain) / 65536.0,
                 real'(sum_abs_plain) / 65536.0 / 65025.0);
        $display("corrected build: error rate %0.2f%%, NMED %0.3e",
                 100.0 * real'(nerr_comp) / 65536.0,
                 real'(sum_abs_comp) / 65536.0 / 65025.0);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule